// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block makes sure that every refresh row of a DRAM is visited within the device's retention time. It holds the address of the next row to refresh and asks a memory arbiter for refresh slots over a request/acknowledge handshake. The arbiter runs the actual row cycle and returns an acknowledge. The row count is the number of refresh cycles the device needs. For a part that refreshes both array halves per cycle, this is half its physical row count: 512 by default.

Two policies are offered and chosen by a mode input. In spread mode one request falls due every retention period divided by the row count; with an 8 ms period this is about every 15.6 µs. In burst mode, one run of row-count back-to-back refreshes starts at the end of every full retention period. With a 165 ns row cycle, a 512-row burst keeps the arbiter busy for about 84.5 µs. If a new refresh falls due while earlier work is still unacknowledged, the block raises a sticky overrun flag. It then keeps serving the old work rather than restarting it.

The timing comes from parameters: clock frequency in MHz, retention period in µs, and row count. The interval in cycles is CLK_MHZ*RETENTION_US/ROWS.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, rfsh_req is 0, row_addr is 0 and overrun is 0.
- R2: In spread mode (burst_mode=0), rfsh_req rises exactly INTERVAL clock edges after reset is released. After that, a new request falls due every INTERVAL edges, where INTERVAL = CLK_MHZ*RETENTION_US/ROWS.
- R3: Once raised, rfsh_req stays high until it is acknowledged. An rfsh_ack while rfsh_req is low changes neither row_addr nor rfsh_req.
- R4: row_addr advances by one on each edge where rfsh_req and rfsh_ack are both high, wrapping from ROWS-1 to 0. It holds otherwise.
- R5: In burst mode (burst_mode=1), rfsh_req rises ROWS*INTERVAL edges after reset and then every ROWS*INTERVAL edges. It stays high through exactly ROWS acknowledges, so a held acknowledge refreshes ROWS consecutive rows on consecutive edges.
- R6: When a new request or burst falls due while earlier work is still unacknowledged after that edge, overrun is set. The pending work carries on unchanged. overrun stays set until ovr_clr is high on an edge, and a new overrun on that same edge keeps it set.
- R7: rfsh_req is low on the edge after the acknowledge that completes the pending work, unless new work falls due on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode | input | 1 | 0 = spread refresh, 1 = burst refresh |
| rfsh_ack | input | 1 | Arbiter accepted the current refresh request |
| ovr_clr | input | 1 | Clears the overrun flag |
| rfsh_req | output | 1 | Refresh request to the arbiter |
| row_addr | output | $clog2(ROWS) | Row to refresh on the current request |
| overrun | output | 1 | Sticky missed-deadline flag |

## Verification
All outputs are registers. An acknowledge shows up in row_addr and rfsh_req on the first edge after it is sampled. An overrun or clear shows up in the flag on that same edge. A due refresh shows up on the INTERVAL-th edge after reset, or the ROWS*INTERVAL-th in burst mode. The bench runs a small configuration of 8 rows with an interval of 8 cycles. It drives and samples one time unit after each rising edge, and counts edges from the release of reset. It then checks each output on exactly the edge where arithmetic on those counts says it must change, and one edge before, through a row-counter wrap and a full burst.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    MODE_SPREAD = 1'b0,
    MODE_BURST  = 1'b1
  } rfsh_mode_e;

  // Cycles between spread-mode requests
  function automatic int unsigned interval_cycles(input int unsigned clk_mhz,
                                                  input int unsigned ret_us,
                                                  input int unsigned rows);
    return (clk_mhz * ret_us) / rows;
  endfunction
endpackage

// File: rtl/rfsh_divider.sv
// Counts enabled cycles and pulses tick_o on the last one of every LIMIT.
module rfsh_divider #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(LIMIT - 1));
  assign tick_o = en_i && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_row_ctr.sv
// Next-row pointer with wrap at ROWS-1.
module rfsh_row_ctr #(
  parameter int unsigned ROWS  = 512,
  localparam int unsigned RW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [RW-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_o <= '0;
    end else if (adv_i) begin
      row_o <= (row_o == RW'(ROWS - 1)) ? '0 : row_o + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned RETENTION_US = 8000,
  parameter int unsigned ROWS         = 512,
  localparam int unsigned RW          = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          burst_mode,
  input  logic          rfsh_ack,
  input  logic          ovr_clr,
  output logic          rfsh_req,
  output logic [RW-1:0] row_addr,
  output logic          overrun
);
  localparam int unsigned INTERVAL = interval_cycles(CLK_MHZ, RETENTION_US, ROWS);
  localparam int unsigned LW       = $clog2(ROWS + 1);

  logic          iv_tick, per_tick;
  logic          accept, start_spread, start_burst, start, clash;
  logic [LW-1:0] left_q, left_dec, left_nxt;
  rfsh_mode_e    mode;

  assign mode = rfsh_mode_e'(burst_mode);

  // One tick per row interval
  rfsh_divider #(.LIMIT(INTERVAL)) u_iv (
    .clk(clk), .rst(rst), .en_i(1'b1), .tick_o(iv_tick)
  );

  // One tick per retention period (ROWS intervals)
  rfsh_divider #(.LIMIT(ROWS)) u_per (
    .clk(clk), .rst(rst), .en_i(iv_tick), .tick_o(per_tick)
  );

  assign accept       = rfsh_req && rfsh_ack;
  assign start_spread = iv_tick  && (mode == MODE_SPREAD);
  assign start_burst  = per_tick && (mode == MODE_BURST);
  assign start        = start_spread || start_burst;

  always_comb begin
    left_dec = accept ? left_q - 1'b1 : left_q;
    clash    = start && (left_dec != '0);
    left_nxt = left_dec;
    if (start && !clash) begin
      left_nxt = start_burst ? LW'(ROWS) : LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      rfsh_req <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      left_q   <= left_nxt;
      rfsh_req <= (left_nxt != '0);
      overrun  <= clash || (overrun && !ovr_clr);
    end
  end

  rfsh_row_ctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst(rst), .adv_i(accept), .row_o(row_addr)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned ROWS = 512,
  localparam int unsigned RW  = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst,
  input logic          rfsh_ack,
  input logic          ovr_clr,
  input logic          rfsh_req,
  input logic [RW-1:0] row_addr,
  input logic          overrun
);
  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && !rfsh_ack) |=> rfsh_req);

  p_row_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(rfsh_req && rfsh_ack) |=> $stable(row_addr));

  p_row_step_r4: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && rfsh_ack) |=>
      (row_addr == (($past(row_addr) == RW'(ROWS - 1)) ? '0 : $past(row_addr) + 1'b1)));

  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);

  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rfsh_req));
endmodule

bind refresh_sched refresh_sched_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .rfsh_ack(rfsh_ack), .ovr_clr(ovr_clr),
  .rfsh_req(rfsh_req), .row_addr(row_addr), .overrun(overrun)
);

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 8;
  localparam int MHZ        = 1;
  localparam int RET_US     = 64;
  localparam int IV         = MHZ * RET_US / ROWS;
  localparam int RW         = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          burst_mode = 1'b0;
  logic          rfsh_ack = 1'b0;
  logic          ovr_clr = 1'b0;
  logic          rfsh_req;
  logic [RW-1:0] row_addr;
  logic          overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  refresh_sched #(.CLK_MHZ(MHZ), .RETENTION_US(RET_US), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst(rst), .burst_mode(burst_mode), .rfsh_ack(rfsh_ack),
    .ovr_clr(ovr_clr), .rfsh_req(rfsh_req), .row_addr(row_addr), .overrun(overrun)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    burst_mode = mode;
    rfsh_ack   = 1'b0;
    ovr_clr    = 1'b0;
    rst        = 1'b1;
    step(2);
    chk("R1 req in reset", int'(rfsh_req), 0);
    chk("R1 row in reset", int'(row_addr), 0);
    chk("R1 ovr in reset", int'(overrun), 0);
    rst = 1'b0;
  endtask

  initial begin
    step(1);
    // Spread mode: timing, handshake, wrap
    do_reset(1'b0);
    for (int k = 0; k < 10; k++) begin
      step((k == 0) ? IV - 1 : IV - 2);
      chk("R2 req low before due", int'(rfsh_req), 0);
      step(1);
      chk("R2 req due", int'(rfsh_req), 1);
      chk("R4 row at request", int'(row_addr), k % ROWS);
      rfsh_ack = 1'b1;
      step(1);
      rfsh_ack = 1'b0;
      chk("R7 req drops after ack", int'(rfsh_req), 0);
      chk("R4 row after ack", int'(row_addr), (k + 1) % ROWS);
    end
    // edge 81 after reset, row 2
    rfsh_ack = 1'b1;
    step(1);
    rfsh_ack = 1'b0;
    chk("R3 stray ack row", int'(row_addr), 2);
    chk("R3 stray ack req", int'(rfsh_req), 0);
    // edge 82 -> request at 88, left pending until 96
    step(6);
    chk("R2 req after stray ack", int'(rfsh_req), 1);
    step(IV);
    chk("R6 overrun set", int'(overrun), 1);
    chk("R3 req still pending", int'(rfsh_req), 1);
    chk("R6 row unchanged", int'(row_addr), 2);
    ovr_clr = 1'b1;
    step(1);
    ovr_clr = 1'b0;
    chk("R6 overrun cleared", int'(overrun), 0);
    rfsh_ack = 1'b1;
    step(1);
    rfsh_ack = 1'b0;
    chk("R4 late ack row", int'(row_addr), 3);
    chk("R7 late ack req", int'(rfsh_req), 0);
    // edge 98 -> request at 104, clash at 112 with clear on same edge
    step(6);
    chk("R2 req at 104", int'(rfsh_req), 1);
    step(7);
    ovr_clr = 1'b1;
    step(1);
    ovr_clr = 1'b0;
    chk("R6 set wins over clear", int'(overrun), 1);

    // Burst mode
    do_reset(1'b1);
    step(ROWS * IV - 1);
    chk("R5 no burst early", int'(rfsh_req), 0);
    step(1);
    chk("R5 burst starts", int'(rfsh_req), 1);
    chk("R5 burst first row", int'(row_addr), 0);
    rfsh_ack = 1'b1;
    for (int j = 1; j <= ROWS; j++) begin
      step(1);
      chk("R5 burst row", int'(row_addr), j % ROWS);
      chk("R5 burst req", int'(rfsh_req), (j < ROWS) ? 1 : 0);
    end
    rfsh_ack = 1'b0;
    step(ROWS * IV - ROWS - 1);
    chk("R5 next burst not early", int'(rfsh_req), 0);
    step(1);
    chk("R5 next burst due", int'(rfsh_req), 1);
    step(ROWS * IV);
    chk("R6 burst overrun", int'(overrun), 1);
    chk("R6 burst keeps request", int'(rfsh_req), 1);
    chk("R6 burst row unchanged", int'(row_addr), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule